// File: doc/BRIEF.md
# Dual-Group Oversampled Baud Clock Generator

This block turns a fixed 3.6864 MHz reference clock into clock-enable pulses at sixteen times a chosen serial bit rate. One clock of `clk` is one reference period. A bank of thirteen free-running dividers runs side by side. Eight of them always produce the same rates. The other five each switch between two rates, and one group-select input decides which of the two groups of five is active. Across both groups the block covers eighteen distinct rates, from 50 to 38400 baud.

The receive path and the transmit path each have a 4-bit selector. Each selector independently picks one of the thirteen divider outputs, the counter/timer enable supplied from outside, or an external clock pin that is synchronised and edge-detected inside the block. Each output is a registered enable, meant to drive the 16x sampling logic of a serial engine.

Top module: `dual_bank_baud_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both `rx_tick_o` and `tx_tick_o` are low. Reset clears every divider count to 0 and makes group A (select value 0) the active group in every switchable divider.
- R2: Codes 0 to 7 select the fixed rates 300, 600, 1200, 2400, 4800, 9600, 19200 and 38400 baud, in that order. Each fixed divider has a period of 230400/baud cycles; for example, 38400 baud gives 6 and 9600 baud gives 24.
- R3: Codes 8 to 12 select the switchable rates. With group A active they are 50, 150, 1800, 7200 and 14400 baud. With group B active they are 75, 200, 900, 3600 and 28800 baud. The divisor is again 230400/baud.
- R4: Each switchable divider samples `bank_sel_i` only in the cycle in which it wraps. A change of the group therefore takes effect from that divider's next period, and no period is ever cut short.
- R5: The receive selector and the transmit selector act independently. Each output depends only on its own code input.
- R6: Code 13 passes `ct_tick_i` through to the output with a delay of one cycle.
- R7: Code 14 produces a single one-cycle pulse for each rising edge of `ext_clk_i`. The pin passes through a two-stage synchroniser, and the pulse appears on the output in the cycle after the third clock edge that follows the change.
- R8: Code 15 is reserved, and an output whose code is 15 stays low.
- R9: All dividers count from 0 after reset. The first pulse of a divider with period D appears at the output in the cycle after the D-th rising edge of `clk` following reset. Later pulses follow every D cycles, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 3.6864 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel_i | input | 1 | Group select for the five switchable rates (0 = group A, 1 = group B) |
| rx_code_i | input | 4 | Receive rate code |
| tx_code_i | input | 4 | Transmit rate code |
| ct_tick_i | input | 1 | Counter/timer enable, in the `clk` domain |
| ext_clk_i | input | 1 | External rate clock, asynchronous |
| rx_tick_o | output | 1 | Receive 16x enable |
| tx_tick_o | output | 1 | Transmit 16x enable |

## Verification
The bench toggles the group select in the middle of divider periods. A design that latched the group at once, or shared one latch between all five dividers, would emit a shortened period that the model does not predict. It steps both codes through every value, including the reserved code, while the dividers are at arbitrary phases. This exposes any swapped table entry, any off-by-one divisor, and any coupling between the receive and transmit selectors. It also drives the external pin and the counter/timer enable with irregular patterns. A design with a missing synchroniser stage, or a level rather than an edge detector, would show a shifted pulse or a stuck-high output.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

   localparam int N_FIXED  = 8;
   localparam int N_SWITCH = 5;
   localparam int N_RATES  = N_FIXED + N_SWITCH;
   localparam int CODE_W   = 4;

   localparam logic [CODE_W-1:0] CODE_CT  = CODE_W'(N_RATES);
   localparam logic [CODE_W-1:0] CODE_EXT = CODE_W'(N_RATES + 1);

   // Baud rate for divider slot idx; grp picks the alternate group for slots >= N_FIXED.
   function automatic int rate_baud(input int idx, input bit grp);
      int fixed_b [N_FIXED];
      int grp_a   [N_SWITCH];
      int grp_b   [N_SWITCH];
      fixed_b = '{300, 600, 1200, 2400, 4800, 9600, 19200, 38400};
      grp_a   = '{50, 150, 1800, 7200, 14400};
      grp_b   = '{75, 200, 900, 3600, 28800};
      if (idx < N_FIXED) return fixed_b[idx];
      return grp ? grp_b[idx-N_FIXED] : grp_a[idx-N_FIXED];
   endfunction

   function automatic int max_divisor(input int ref_hz, input int oversample);
      int m;
      m = 1;
      for (int i = 0; i < N_RATES; i++) begin
         for (int g = 0; g < 2; g++) begin
            if (ref_hz / (oversample * rate_baud(i, g[0])) > m)
               m = ref_hz / (oversample * rate_baud(i, g[0]));
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/bgen_divider.sv
module bgen_divider #(
   parameter int DIV_A      = 16,
   parameter int DIV_B      = 16,
   parameter bit SWITCHABLE = 1'b0,
   parameter int CNT_W      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bank_sel_i,
   output logic tick_o
);

   localparam logic [CNT_W-1:0] LAST_A = CNT_W'(DIV_A - 1);
   localparam logic [CNT_W-1:0] LAST_B = CNT_W'(DIV_B - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   if (DIV_A < 2 || DIV_B < 2) begin : g_bad_div
      $error("bgen_divider: divisor below 2");
   end

   if (SWITCHABLE) begin : g_switch
      logic grp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      grp_q <= 1'b0;
         else if (tick_o) grp_q <= bank_sel_i;
      end
      assign last = grp_q ? LAST_B : LAST_A;
   end else begin : g_fixed
      logic unused_sel;
      assign unused_sel = bank_sel_i;
      assign last = LAST_A;
   end

   assign tick_o = (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/bgen_edge_sync.sv
module bgen_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   logic [STAGES:0] sh_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("bgen_edge_sync: at least two synchroniser stages required");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], async_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/bgen_select.sv
module bgen_select
   import bgen_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   input  logic [N_RATES-1:0] rate_tick_i,
   input  logic              ct_tick_i,
   input  logic              ext_tick_i,
   output logic              tick_o
);

   logic pick;

   always_comb begin
      pick = 1'b0;
      for (int k = 0; k < N_RATES; k++) begin
         if (code_i == CODE_W'(k)) pick = rate_tick_i[k];
      end
      if (code_i == CODE_CT)  pick = ct_tick_i;
      if (code_i == CODE_EXT) pick = ext_tick_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_o <= 1'b0;
      else        tick_o <= pick;
   end

endmodule

// File: rtl/dual_bank_baud_gen.sv
module dual_bank_baud_gen
   import bgen_pkg::*;
#(
   parameter int REF_HZ      = 3686400,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_sel_i,
   input  logic [CODE_W-1:0] rx_code_i,
   input  logic [CODE_W-1:0] tx_code_i,
   input  logic              ct_tick_i,
   input  logic              ext_clk_i,
   output logic              rx_tick_o,
   output logic              tx_tick_o
);

   localparam int DIV_W = $clog2(max_divisor(REF_HZ, OVERSAMPLE) + 1);

   logic [N_RATES-1:0] rate_tick;
   logic               ext_rise;

   if (CODE_EXT >= {CODE_W{1'b1}}) begin : g_bad_codes
      $error("dual_bank_baud_gen: no reserved code left");
   end

   for (genvar i = 0; i < N_RATES; i++) begin : g_rate
      localparam int BAUD_A = rate_baud(i, 1'b0);
      localparam int BAUD_B = rate_baud(i, 1'b1);
      localparam int DIV_A  = REF_HZ / (OVERSAMPLE * BAUD_A);
      localparam int DIV_B  = REF_HZ / (OVERSAMPLE * BAUD_B);

      if ((REF_HZ % (OVERSAMPLE * BAUD_A)) != 0 ||
          (REF_HZ % (OVERSAMPLE * BAUD_B)) != 0) begin : g_inexact
         $error("dual_bank_baud_gen: reference not an exact multiple of a rate");
      end

      bgen_divider #(
         .DIV_A      (DIV_A),
         .DIV_B      (DIV_B),
         .SWITCHABLE (i >= N_FIXED),
         .CNT_W      (DIV_W)
      ) u_div (
         .clk        (clk),
         .rst_n      (rst_n),
         .bank_sel_i (bank_sel_i),
         .tick_o     (rate_tick[i])
      );
   end

   bgen_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ext_clk_i),
      .rise_o  (ext_rise)
   );

   bgen_select u_rx_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .code_i      (rx_code_i),
      .rate_tick_i (rate_tick),
      .ct_tick_i   (ct_tick_i),
      .ext_tick_i  (ext_rise),
      .tick_o      (rx_tick_o)
   );

   bgen_select u_tx_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .code_i      (tx_code_i),
      .rate_tick_i (rate_tick),
      .ct_tick_i   (ct_tick_i),
      .ext_tick_i  (ext_rise),
      .tick_o      (tx_tick_o)
   );

endmodule

// File: rtl/dual_bank_baud_gen_chk.sv
module dual_bank_baud_gen_chk
   import bgen_pkg::*;
#(
   parameter int REF_HZ     = 3686400,
   parameter int OVERSAMPLE = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bank_sel_i,
   input logic [CODE_W-1:0] rx_code_i,
   input logic [CODE_W-1:0] tx_code_i,
   input logic              ct_tick_i,
   input logic              ext_clk_i,
   input logic              rx_tick_o,
   input logic              tx_tick_o
);

   localparam logic [CODE_W-1:0] FAST_CODE = CODE_W'(N_FIXED - 1);
   localparam int FAST_DIV = REF_HZ / (OVERSAMPLE * rate_baud(N_FIXED - 1, 1'b0));
   localparam logic [CODE_W-1:0] RSV_CODE = {CODE_W{1'b1}};

   logic [15:0]       gap_q;
   logic              clean_q;
   logic [CODE_W-1:0] txc_q;
   logic [CODE_W-1:0] rxc_q;
   logic              unused_in;

   assign unused_in = bank_sel_i ^ ext_clk_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q   <= '0;
         clean_q <= 1'b0;
         txc_q   <= RSV_CODE;
         rxc_q   <= RSV_CODE;
      end else begin
         txc_q <= tx_code_i;
         rxc_q <= rx_code_i;
         if (tx_tick_o) begin
            gap_q   <= '0;
            clean_q <= (tx_code_i == FAST_CODE) && (txc_q == FAST_CODE);
         end else begin
            if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
            if (tx_code_i != FAST_CODE) clean_q <= 1'b0;
         end
      end
   end

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rx_tick_o && !tx_tick_o)); // R1

   AST_FAST_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_tick_o && clean_q) |-> (gap_q == 16'(FAST_DIV - 1))); // R2

   AST_RX_CT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_code_i == CODE_CT) |=> (rx_tick_o == $past(ct_tick_i))); // R6

   AST_TX_CT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_code_i == CODE_CT) |=> (tx_tick_o == $past(ct_tick_i))); // R6

   AST_EXT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_tick_o && rx_code_i == CODE_EXT && rxc_q == CODE_EXT) |=> !rx_tick_o); // R7

   AST_RX_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_code_i == RSV_CODE) |=> !rx_tick_o); // R8

   AST_TX_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_code_i == RSV_CODE) |=> !tx_tick_o); // R8

endmodule

bind dual_bank_baud_gen dual_bank_baud_gen_chk #(
   .REF_HZ     (REF_HZ),
   .OVERSAMPLE (OVERSAMPLE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bank_sel_i (bank_sel_i),
   .rx_code_i  (rx_code_i),
   .tx_code_i  (tx_code_i),
   .ct_tick_i  (ct_tick_i),
   .ext_clk_i  (ext_clk_i),
   .rx_tick_o  (rx_tick_o),
   .tx_tick_o  (tx_tick_o)
);

// File: tb/tb_dual_bank_baud_gen.sv
module tb_dual_bank_baud_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bank_sel_i = 1'b0;
   logic [3:0] rx_code_i = 4'd15;
   logic [3:0] tx_code_i = 4'd15;
   logic       ct_tick_i = 1'b0;
   logic       ext_clk_i = 1'b0;
   logic       rx_tick_o;
   logic       tx_tick_o;

   int checks = 0;
   int fails  = 0;
   string phase = "R9";
   bit done = 1'b0;
   int rsv_ticks = 0;

   always #4 clk = ~clk;

   dual_bank_baud_gen dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_sel_i (bank_sel_i),
      .rx_code_i  (rx_code_i),
      .tx_code_i  (tx_code_i),
      .ct_tick_i  (ct_tick_i),
      .ext_clk_i  (ext_clk_i),
      .rx_tick_o  (rx_tick_o),
      .tx_tick_o  (tx_tick_o)
   );

   // ---------------- behavioural reference model ----------------
   int fixed_b [8] = '{300, 600, 1200, 2400, 4800, 9600, 19200, 38400};
   int grp_a   [5] = '{50, 150, 1800, 7200, 14400};
   int grp_b   [5] = '{75, 200, 900, 3600, 28800};

   int m_cnt [13];
   bit m_grp [5];
   bit m_e1, m_e2, m_e3;
   bit exp_rx, exp_tx;

   function automatic int period_of(int k, bit g);
      int b;
      if (k < 8) b = fixed_b[k];
      else       b = g ? grp_b[k-8] : grp_a[k-8];
      return 230400 / b;
   endfunction

   function automatic bit choose(int code, bit [12:0] t, bit ct, bit er);
      if (code < 13)  return t[code];
      if (code == 13) return ct;
      if (code == 14) return er;
      return 1'b0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 13; k++) m_cnt[k] = 0;
         for (int k = 0; k < 5; k++)  m_grp[k] = 1'b0;
         m_e1 = 0; m_e2 = 0; m_e3 = 0;
         exp_rx = 0; exp_tx = 0;
      end else begin
         bit [12:0] t;
         bit er;
         for (int k = 0; k < 13; k++) begin
            int p;
            p = (k < 8) ? period_of(k, 1'b0) : period_of(k, m_grp[k-8]);
            t[k] = (m_cnt[k] == p - 1);
         end
         er = m_e2 && !m_e3;
         exp_rx = choose(int'(rx_code_i), t, ct_tick_i, er);
         exp_tx = choose(int'(tx_code_i), t, ct_tick_i, er);
         for (int k = 0; k < 13; k++) begin
            if (t[k]) begin
               m_cnt[k] = 0;
               if (k >= 8) m_grp[k-8] = bank_sel_i;
            end else begin
               m_cnt[k] = m_cnt[k] + 1;
            end
         end
         m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk_i;
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (rx_tick_o !== exp_rx) begin
            fails++;
            $display("FAIL %s rx code %0d: actual %b expected %b at %0t",
                     phase, rx_code_i, rx_tick_o, exp_rx, $time);
         end
         checks++;
         if (tx_tick_o !== exp_tx) begin
            fails++;
            $display("FAIL R5 %s tx code %0d: actual %b expected %b at %0t",
                     phase, tx_code_i, tx_tick_o, exp_tx, $time);
         end
         if (rx_code_i == 4'd15 && rx_tick_o) rsv_ticks++;
      end
   end

   // ---------------- irregular side stimulus ----------------
   initial begin
      forever begin
         @(negedge clk);
         ct_tick_i = ($urandom_range(0, 3) == 0);
      end
   end

   initial begin
      forever begin
         repeat ($urandom_range(4, 30)) @(negedge clk);
         ext_clk_i = ~ext_clk_i;
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // ---------------- main sequence ----------------
   initial begin
      phase = "R1";
      run(5);
      @(negedge clk);
      rst_n = 1'b1;
      rx_code_i = 4'd7;
      tx_code_i = 4'd0;
      phase = "R9";
      run(1600);

      phase = "R2";
      for (int c = 0; c < 13; c++) begin
         if (c >= 8) phase = "R3";
         rx_code_i = 4'(c);
         tx_code_i = 4'(12 - c);
         run(2500);
      end

      phase = "R4";
      bank_sel_i = 1'b1;
      for (int c = 8; c < 13; c++) begin
         rx_code_i = 4'(c);
         tx_code_i = 4'(20 - c);
         run(5000);
      end
      rx_code_i = 4'd12;
      tx_code_i = 4'd11;
      for (int r = 0; r < 6; r++) begin
         run(37 + 11 * r);
         bank_sel_i = ~bank_sel_i;
      end
      run(400);

      phase = "R6";
      rx_code_i = 4'd13;
      tx_code_i = 4'd14;
      run(3000);
      phase = "R7";
      rx_code_i = 4'd14;
      tx_code_i = 4'd13;
      run(3000);

      phase = "R8";
      rsv_ticks = 0;
      rx_code_i = 4'd15;
      tx_code_i = 4'd7;
      run(3000);
      checks++;
      if (rsv_ticks != 0) begin
         fails++;
         $display("FAIL R8 reserved code pulses: actual %0d expected 0", rsv_ticks);
      end

      phase = "R1";
      rst_n = 1'b0;
      run(3);
      @(negedge clk);
      rst_n = 1'b1;
      rx_code_i = 4'd5;
      tx_code_i = 4'd10;
      run(2000);
      summary();
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule